// File: doc/BRIEF.md
# Configurable External Interrupt Sensing Unit

This block sits between three active-low external interrupt request pins and a program sequencer. Each pin is brought into the core clock domain through a two-flop synchronizer. Its value is then inspected only on a strobe that fires every second core clock, which gives a sampling rate of half the core clock. A per-line mode bit chooses how a sampled value becomes a request. In edge mode, a high-to-low transition between two consecutive samples latches a pending request. That request stays pending until the sequencer signals that service has started. In level mode, the pending bit follows the sampled level. A line whose service has started is not raised again until its return-from-service pulse. If the pin is still low at the first sample after that return, the line becomes pending again.

The sequencer reads the pending vector and a priority result. The priority result is the index of the lowest-numbered pending line and a valid flag. The sequencer then pulses the per-line service-start and return-from-service inputs as it enters and leaves each routine. Changing a line's mode bit discards that line's pending request and its service state. A pin that is already low when its line is switched into edge mode does not count as a new edge.

Top module: `irq_sense_top`

## Requirements
- R1: After reset the pending vector is 000 and the valid flag is 0.
- R2: In level mode (mode bit 0), a pin held low sets its pending bit within four core clocks, at a sample strobe.
- R3: Pins are looked at only on the sample strobe, which fires on every second core clock edge after reset. A low lasting one core clock that misses the strobe raises no request. The same pulse aligned with the strobe does raise one.
- R4: In edge mode (mode bit 1), a high sample followed by a low sample sets the pending bit. After a service-start pulse clears it, a pin that stays low raises no further request.
- R5: In edge mode, returning the pin high and then driving it low again raises a new request.
- R6: In level mode, a service-start pulse clears the pending bit, and the bit stays clear while the line is in service, even with the pin low. If the pin is still low after the return-from-service pulse, the bit is set again at the next sample.
- R7: In level mode, a pending line that is not in service clears when the pin is sampled high.
- R8: Mode bit n selects the sensitivity of line n alone (bit 0 is line 0, bit 1 is line 1, bit 2 is line 2).
- R9: The priority index names the lowest-numbered pending line, so line 0 wins. The valid flag is 1 exactly when any line is pending.
- R10: Changing a line's mode bit clears that line's pending bit. A pin already low when the line enters edge mode raises no request until it rises and falls again.
- R11: In edge mode, when a new edge is sampled in the same cycle as that line's service-start pulse, the pending bit stays set.
- R12: In edge mode, the return-from-service pulse has no effect on the pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n_i | input | 3 | Raw interrupt request pins, active low, one per line |
| edge_mode_i | input | 3 | Per-line sensitivity: 1 edge, 0 level |
| svc_start_i | input | 3 | Per-line one-cycle pulse: service routine entered |
| svc_return_i | input | 3 | Per-line one-cycle pulse: service routine left |
| pending_o | output | 3 | Latched pending requests |
| top_idx_o | output | 2 | Index of the highest-priority pending line |
| top_valid_o | output | 1 | At least one line pending |

## Verification
Two of this block's functions can fall in the same cycle for an edge-mode line: the service-start pulse clears the pending bit, and a freshly sampled fall sets it. The bench counts core clock edges from reset and uses that count to place a new falling edge so that it reaches the sampler on exactly the strobe cycle in which service-start is pulsed. The pending bit was already set before this step, so a design that lets the clear win ends with the bit at 0. Only a design that keeps the new request ends with the bit at 1.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;

    // Per-line registered state of the sensing path
    typedef struct packed {
        logic s1;      // first synchronizer flop
        logic s2;      // second synchronizer flop
        logic last;    // value seen at the previous sample strobe
        logic pend;    // latched request
        logic in_svc;  // level line whose routine is running
        logic mode;    // registered copy of the sensitivity bit
    } line_state_t;

    localparam line_state_t LINE_RESET = '{
        s1: 1'b1, s2: 1'b1, last: 1'b1, pend: 1'b0, in_svc: 1'b0, mode: 1'b0
    };

endpackage

// File: rtl/irq_sample_strobe.sv
module irq_sample_strobe (
    input  logic clk,
    input  logic rst_n,
    output logic sample_en_o
);

    logic strobe_d, strobe_q;

    always_comb begin
        strobe_d = ~strobe_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe_d;
    end

    assign sample_en_o = strobe_q;

endmodule

// File: rtl/irq_line_sense.sv
module irq_line_sense
    import irq_sense_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_n_i,
    input  logic edge_mode_i,
    input  logic sample_en_i,
    input  logic svc_start_i,
    input  logic svc_return_i,
    output logic pend_o
);

    line_state_t st_d, st_q;
    logic        mode_chg;
    logic        fall;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = req_n_i;
        st_d.s2   = st_q.s1;
        st_d.mode = edge_mode_i;
        mode_chg  = (edge_mode_i != st_q.mode);
        fall      = st_q.last & ~st_q.s2;

        if (mode_chg) begin
            // drop request and service state; history follows the current pin
            st_d.pend   = 1'b0;
            st_d.in_svc = 1'b0;
            st_d.last   = st_q.s2;
        end else if (st_q.mode) begin
            // edge sensitivity: a sampled fall beats a coincident clear
            if (svc_start_i) st_d.pend = 1'b0;
            if (sample_en_i) begin
                st_d.last = st_q.s2;
                if (fall) st_d.pend = 1'b1;
            end
        end else begin
            // level sensitivity
            if (svc_start_i) begin
                st_d.pend   = 1'b0;
                st_d.in_svc = 1'b1;
            end
            if (svc_return_i) st_d.in_svc = 1'b0;
            if (sample_en_i) begin
                st_d.last = st_q.s2;
                st_d.pend = ~st_q.s2 & ~st_d.in_svc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LINE_RESET;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    // R10: a mode flip leaves the line idle on the next cycle
    p_mode_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode_i != st_q.mode) |=> !pend_o);

    // R6: no level request while the routine runs
    p_no_raise_in_svc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.in_svc && !svc_return_i) |=> !pend_o);

    // R3: off-strobe cycles with no pulses leave the request untouched
    p_sample_only_on_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_en_i && (edge_mode_i == st_q.mode) && !svc_start_i && !svc_return_i)
        |=> $stable(pend_o));

    // R4: an edge line whose last sample was low cannot gain a request
    p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode && (edge_mode_i == st_q.mode) && !svc_start_i && !st_q.last)
        |=> $stable(pend_o));

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N_LINES = 3,
    localparam int IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] pend_i,
    output logic [IDX_W-1:0]   idx_o,
    output logic               valid_o
);

    always_comb begin
        idx_o   = '0;
        valid_o = 1'b0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                idx_o   = IDX_W'(i);
                valid_o = 1'b1;
            end
        end
    end

    // R9: valid tracks the vector and the index names a set bit
    p_valid_matches_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o == (pend_i != '0));

    p_idx_is_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> pend_i[idx_o]);

    p_idx_is_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((pend_i & ((N_LINES'(1) << idx_o) - N_LINES'(1))) == '0));

endmodule

// File: rtl/irq_sense_top.sv
module irq_sense_top #(
    parameter int N_LINES = 3,
    localparam int IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] req_n_i,
    input  logic [N_LINES-1:0] edge_mode_i,
    input  logic [N_LINES-1:0] svc_start_i,
    input  logic [N_LINES-1:0] svc_return_i,
    output logic [N_LINES-1:0] pending_o,
    output logic [IDX_W-1:0]   top_idx_o,
    output logic               top_valid_o
);

    logic sample_en;

    irq_sample_strobe u_strobe (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_en_o (sample_en)
    );

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        irq_line_sense u_line (
            .clk          (clk),
            .rst_n        (rst_n),
            .req_n_i      (req_n_i[g]),
            .edge_mode_i  (edge_mode_i[g]),
            .sample_en_i  (sample_en),
            .svc_start_i  (svc_start_i[g]),
            .svc_return_i (svc_return_i[g]),
            .pend_o       (pending_o[g])
        );
    end

    irq_prio_pick #(.N_LINES(N_LINES)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_i  (pending_o),
        .idx_o   (top_idx_o),
        .valid_o (top_valid_o)
    );

endmodule

// File: tb/tb_irq_sense_top.sv
`timescale 1ns/1ps
module tb_irq_sense_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] req_n = 3'b111;
    logic [2:0] mode = 3'b000;
    logic [2:0] start = 3'b000;
    logic [2:0] ret = 3'b000;
    logic [2:0] pending;
    logic [1:0] idx;
    logic       valid;

    int n_checks = 0;
    int n_fail = 0;
    int edge_cnt = 0;

    always #2 clk = ~clk;  // 250 MHz

    always @(posedge clk) begin
        if (!rst_n) edge_cnt <= 0;
        else        edge_cnt <= edge_cnt + 1;
    end

    irq_sense_top dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_n_i      (req_n),
        .edge_mode_i  (mode),
        .svc_start_i  (start),
        .svc_return_i (ret),
        .pending_o    (pending),
        .top_idx_o    (idx),
        .top_valid_o  (valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // wait for a negedge at which edge_cnt has the requested parity
    task automatic align(input int par);
        @(negedge clk);
        while ((edge_cnt % 2) != par) @(negedge clk);
    endtask

    task automatic pulse_start(input logic [2:0] m);
        start = m; cyc(1); start = 3'b000;
    endtask

    task automatic pulse_ret(input logic [2:0] m);
        ret = m; cyc(1); ret = 3'b000;
    endtask

    task automatic idle(input logic [2:0] m);
        req_n = 3'b111; mode = m; start = '0; ret = '0; cyc(6);
    endtask

    task automatic t_reset;
        chk("R1 pending", pending, 0);
        chk("R1 valid", valid, 0);
    endtask

    task automatic t_level;
        idle(3'b000);
        req_n = 3'b101; cyc(4);
        chk("R2 line1 pending", pending, 3'b010);
        chk("R9 idx line1", idx, 1);
        req_n = 3'b100; cyc(4);
        chk("R9 two pending", pending, 3'b011);
        chk("R9 idx lowest", idx, 0);
        chk("R9 valid set", valid, 1);
        req_n = 3'b111; cyc(4);
        chk("R7 cleared on high", pending, 0);
        chk("R9 valid clear", valid, 0);
    endtask

    task automatic t_glitch;
        idle(3'b000);
        align(0);                       // fall misses the strobe
        req_n = 3'b110; cyc(1); req_n = 3'b111; cyc(4);
        chk("R3 glitch ignored", pending, 0);
        align(1);                       // same pulse on the strobe
        req_n = 3'b110; cyc(1); req_n = 3'b111; cyc(2);
        chk("R3 aligned pulse seen", pending, 3'b001);
        cyc(3);
        chk("R7 aligned pulse gone", pending, 0);
    endtask

    task automatic t_edge;
        idle(3'b001);
        req_n = 3'b110; cyc(4);
        chk("R4 fall sets", pending, 3'b001);
        pulse_ret(3'b001); cyc(2);
        chk("R12 return ignored", pending, 3'b001);
        pulse_start(3'b001);
        chk("R4 start clears", pending, 0);
        cyc(6);
        chk("R4 held low no repeat", pending, 0);
        req_n = 3'b111; cyc(4);
        req_n = 3'b110; cyc(4);
        chk("R5 new fall", pending, 3'b001);
        pulse_start(3'b001);
    endtask

    task automatic t_mapping;
        idle(3'b010);
        req_n = 3'b100; cyc(4);
        chk("R8 both pending", pending, 3'b011);
        pulse_start(3'b011); cyc(6);
        chk("R8 both cleared", pending, 0);
        pulse_ret(3'b011); cyc(4);
        chk("R8 only level line0 returns", pending, 3'b001);
    endtask

    task automatic t_level_svc;
        idle(3'b000);
        req_n = 3'b011; cyc(4);
        chk("R6 line2 pending", pending, 3'b100);
        chk("R9 idx line2", idx, 2);
        pulse_start(3'b100);
        chk("R6 start clears", pending, 0);
        cyc(6);
        chk("R6 not raised in service", pending, 0);
        pulse_ret(3'b100); cyc(4);
        chk("R6 re-raised after return", pending, 3'b100);
        req_n = 3'b111; cyc(4);
    endtask

    task automatic t_modechg;
        idle(3'b000);
        req_n = 3'b110; cyc(4);
        chk("R10 level pending", pending, 3'b001);
        mode = 3'b001; cyc(1);
        chk("R10 flip clears", pending, 0);
        cyc(6);
        chk("R10 held low no edge", pending, 0);
        req_n = 3'b111; cyc(4);
        req_n = 3'b110; cyc(4);
        chk("R10 real edge after flip", pending, 3'b001);
    endtask

    task automatic t_collide;
        idle(3'b001);
        req_n = 3'b110; cyc(4);
        chk("R11 first edge", pending, 3'b001);
        req_n = 3'b111; cyc(4);
        align(1);                       // fall sampled at edge_cnt+3
        req_n = 3'b110; cyc(2);
        start = 3'b001; cyc(1); start = 3'b000;
        chk("R11 set beats clear", pending, 3'b001);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_level();
        t_glitch();
        t_edge();
        t_mapping();
        t_level_svc();
        t_modechg();
        t_collide();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule